// File: doc/BRIEF.md
# Rotating Pulse Distributor for Series Cell Power Balance

This block sits between the random PWM pulse generator of one inverter phase and the gate drive of the three series low-voltage H-bridge cells of that phase. The generator produces one pulse train per voltage band for each of the two half-bridge legs. The distributor decides which cell receives which band. The assignment rotates by one position each time a half-fundamental-period strobe arrives. Over three half periods, which is one and a half fundamental periods, every cell has carried every band once on each leg. The average power drawn from each cell is therefore equal, and neither the carriers nor the modulation waves have to be rebuilt.

Rotation is done by gating with window signals. A small state machine keeps a phase number from 0 to NCELL-1. In each phase exactly one leg-1 window and one leg-2 window are active: leg-1 window of phase p is `win[2p]` and leg-2 window is `win[2p+1]`. The machine has four states. ST_HOLD is entered at reset, with no window open and all cells at zero output. ST_START_WAIT is entered when the first strobe arrives on a noisy edge. ST_RUN means the windows are open. ST_STEP_WAIT means a strobe is pending while the windows are open.

The transitions are as follows:
- ST_HOLD goes to ST_RUN on a strobe at a quiet edge, or to ST_START_WAIT on a strobe at a noisy edge.
- ST_START_WAIT goes to ST_RUN at the next quiet edge.
- ST_RUN stays in ST_RUN and advances the phase on a strobe at a quiet edge, or goes to ST_STEP_WAIT on a strobe at a noisy edge.
- ST_STEP_WAIT goes to ST_RUN and advances the phase at the next quiet edge.

An edge is quiet when no band input differs from its value at the previous edge. This keeps a window change from cutting a pulse short and producing a glitch.

Top module: `cell_pulse_rotator`

## Requirements
- R1: After reset, and until the first strobe is committed, every cell is in the zero state. In each cell's nibble `gate_o[4c+3:4c]`, bit 0 is leg-1 upper, bit 1 is leg-1 lower, bit 2 is leg-2 upper and bit 3 is leg-2 lower. The zero state is 4'b1010, whatever the band inputs do.
- R2: The first committed strobe after reset selects phase 0. The new routing is visible right after the clock edge that commits the strobe.
- R3: Each later committed strobe advances the phase 0→1→2→0, so the assignment repeats every three half periods.
- R4: In phase p, cell 0's leg-1 upper switch follows leg-1 band bit [0,2,1][p] and its leg-2 upper switch follows leg-2 band bit [1,0,2][p]. Bit b is band b+1.
- R5: Cell c uses the band index of cell 0 plus c, modulo 3, for both legs.
- R6: In every cell the leg-1 lower bit is the complement of the leg-1 upper bit, and the leg-2 lower bit is the complement of the leg-2 upper bit.
- R7: A strobe at an edge where a band input changed does not alter the routing. The change is committed at the first later edge where no band input changes.
- R8: Further strobes that arrive while a change is pending are absorbed, so the phase advances by exactly one.
- R9: While windows are open, each band of each leg drives exactly one cell. The number of upper switches on per leg equals the number of band pulses high on that leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_strobe | input | 1 | One-cycle pulse at each half-fundamental-period boundary |
| leg1_band | input | NCELL | Band pulses for the first half-bridge leg, bit b = band b+1 |
| leg2_band | input | NCELL | Band pulses for the second half-bridge leg, bit b = band b+1 |
| gate_o | output | 4*NCELL | Gate signals, one nibble per cell (see R1 for bit order) |

## Verification
The hardest state to reach from the ports is a deferred window change, especially one that absorbs extra strobes. Reaching it needs a strobe on the same cycle that a band input toggles, and then continued toggling while more strobes arrive. The bench drives the strobe and a new band pattern on the same falling edge, repeats this on the next cycle, and then holds the bands. It then checks that the old routing survives exactly until the first quiet edge and that the phase moves by only one step. The same trick is applied from the reset hold state to reach ST_START_WAIT.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
    typedef enum logic [1:0] {
        ST_HOLD       = 2'd0,
        ST_START_WAIT = 2'd1,
        ST_RUN        = 2'd2,
        ST_STEP_WAIT  = 2'd3
    } seq_state_e;

    localparam int GATES_PER_CELL = 4;
endpackage

// File: rtl/rpd_quiet_det.sv
// Flags a clock edge at which no band input differs from its value at the
// previous edge; window changes are allowed only on such edges.
module rpd_quiet_det #(
    parameter int NBAND = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBAND-1:0] leg_a,
    input  logic [NBAND-1:0] leg_b,
    output logic             quiet
);
    logic [NBAND-1:0] leg_a_q;
    logic [NBAND-1:0] leg_b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            leg_a_q <= '0;
            leg_b_q <= '0;
        end else begin
            leg_a_q <= leg_a;
            leg_b_q <= leg_b;
        end
    end

    always_comb begin
        quiet = (leg_a == leg_a_q) && (leg_b == leg_b_q);
    end
endmodule

// File: rtl/rpd_window_seq.sv
// Window sequencer: holds the rotation phase and opens one leg-1 and one
// leg-2 window per phase (leg-1 window of phase p is win[2p], leg-2 is win[2p+1]).
module rpd_window_seq
    import rpd_pkg::*;
#(
    parameter int NPHASE = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic                quiet,
    output logic [2*NPHASE-1:0] win
);
    localparam int NW = 2 * NPHASE;
    localparam int PW = (NPHASE > 1) ? $clog2(NPHASE) : 1;
    localparam logic [PW-1:0] LAST_PH = PW'(NPHASE - 1);

    seq_state_e    state_q, state_nx;
    logic [PW-1:0] phase_q, phase_nx;
    logic [PW-1:0] phase_step;

    always_comb begin
        phase_step = (phase_q == LAST_PH) ? '0 : phase_q + PW'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            phase_q <= '0;
        end else begin
            state_q <= state_nx;
            phase_q <= phase_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        phase_nx = phase_q;
        unique case (state_q)
            ST_HOLD: begin
                if (strobe) begin
                    if (quiet) begin
                        state_nx = ST_RUN;
                        phase_nx = '0;
                    end else begin
                        state_nx = ST_START_WAIT;
                    end
                end
            end
            ST_START_WAIT: begin
                if (quiet) begin
                    state_nx = ST_RUN;
                    phase_nx = '0;
                end
            end
            ST_RUN: begin
                if (strobe) begin
                    if (quiet) begin
                        phase_nx = phase_step;
                    end else begin
                        state_nx = ST_STEP_WAIT;
                    end
                end
            end
            ST_STEP_WAIT: begin
                if (quiet) begin
                    state_nx = ST_RUN;
                    phase_nx = phase_step;
                end
            end
            default: begin
                state_nx = ST_HOLD;
                phase_nx = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        win = '0;
        unique case (state_q)
            ST_RUN, ST_STEP_WAIT: begin
                for (int p = 0; p < NPHASE; p++) begin
                    if (phase_q == PW'(p)) begin
                        win[2*p]   = 1'b1;
                        win[2*p+1] = 1'b1;
                    end
                end
            end
            default: win = '0;
        endcase
    end

    logic [NPHASE-1:0] win_leg1, win_leg2;
    for (genvar p = 0; p < NPHASE; p++) begin : g_split
        assign win_leg1[p] = win[2*p];
        assign win_leg2[p] = win[2*p+1];
    end

    // R3: one leg-1 and one leg-2 window at a time, or none
    p_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(win_leg1) == $countones(win_leg2)) && $onehot0(win_leg1));

    // R7: windows change only at edges where the bands were steady
    p_quiet_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(win) |-> $past(quiet));

    // R3 / R8: a change needs a strobe now or one pending from before
    p_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(win) |-> ($past(strobe) || $past(state_q == ST_START_WAIT)
                           || $past(state_q == ST_STEP_WAIT)));

    // R3: an open window pair only moves one phase forward, cyclically
    p_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(win) != '0) && !$stable(win)) |->
        (win == {$past(win[NW-3:0]), $past(win[NW-1:NW-2])}));
endmodule

// File: rtl/rpd_cell_router.sv
// Routes one band per leg to a single cell according to the open window.
module rpd_cell_router
    import rpd_pkg::*;
#(
    parameter int NCELL = 3,
    parameter int CELL  = 0
) (
    input  logic [NCELL-1:0]          leg_a,
    input  logic [NCELL-1:0]          leg_b,
    input  logic [2*NCELL-1:0]        win,
    output logic [GATES_PER_CELL-1:0] gates
);
    logic [NCELL-1:0] pick_a, pick_b;
    logic             up_a, up_b;

    for (genvar p = 0; p < NCELL; p++) begin : g_phase
        localparam int BAND_A = (CELL + NCELL - p) % NCELL;
        localparam int BAND_B = (CELL + 1 + NCELL - p) % NCELL;
        assign pick_a[p] = win[2*p]   & leg_a[BAND_A];
        assign pick_b[p] = win[2*p+1] & leg_b[BAND_B];
    end

    always_comb begin
        up_a  = |pick_a;
        up_b  = |pick_b;
        gates = {~up_b, up_b, ~up_a, up_a};
    end
endmodule

// File: rtl/cell_pulse_rotator.sv
module cell_pulse_rotator
    import rpd_pkg::*;
#(
    parameter int NCELL = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        half_strobe,
    input  logic [NCELL-1:0]            leg1_band,
    input  logic [NCELL-1:0]            leg2_band,
    output logic [GATES_PER_CELL*NCELL-1:0] gate_o
);
    localparam int NW = 2 * NCELL;

    logic          quiet;
    logic [NW-1:0] win;

    rpd_quiet_det #(.NBAND(NCELL)) u_quiet (
        .clk   (clk),
        .rst_n (rst_n),
        .leg_a (leg1_band),
        .leg_b (leg2_band),
        .quiet (quiet)
    );

    rpd_window_seq #(.NPHASE(NCELL)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (half_strobe),
        .quiet  (quiet),
        .win    (win)
    );

    logic [NCELL-1:0] up1_vec, lo1_vec, up2_vec, lo2_vec;

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        rpd_cell_router #(.NCELL(NCELL), .CELL(c)) u_router (
            .leg_a (leg1_band),
            .leg_b (leg2_band),
            .win   (win),
            .gates (gate_o[GATES_PER_CELL*c +: GATES_PER_CELL])
        );
        assign up1_vec[c] = gate_o[GATES_PER_CELL*c];
        assign lo1_vec[c] = gate_o[GATES_PER_CELL*c+1];
        assign up2_vec[c] = gate_o[GATES_PER_CELL*c+2];
        assign lo2_vec[c] = gate_o[GATES_PER_CELL*c+3];
    end

    // R1: with no window open every cell sits in the zero state
    p_hold_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (win == '0) |-> ((up1_vec == '0) && (up2_vec == '0)
                         && (&lo1_vec) && (&lo2_vec)));

    // R9: each band pulse of each leg lands on exactly one cell
    p_distinct_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (win != '0) |-> (($countones(up1_vec) == $countones(leg1_band))
                         && ($countones(up2_vec) == $countones(leg2_band))));
endmodule

// File: tb/cell_pulse_rotator_test.sv
module cell_pulse_rotator_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCELL = 3;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 half_strobe;
    logic [NCELL-1:0]     leg1_band, leg2_band;
    logic [4*NCELL-1:0]   gate_o;

    int checks = 0;
    int errors = 0;
    int ph = -1;        // bench model phase, -1 = hold
    bit finished = 0;

    cell_pulse_rotator #(.NCELL(NCELL)) uut (
        .clk(clk), .rst_n(rst_n), .half_strobe(half_strobe),
        .leg1_band(leg1_band), .leg2_band(leg2_band), .gate_o(gate_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // band tables from R4 and R5
    function automatic int band1(int c, int p);
        int t [3][3] = '{'{0, 2, 1}, '{1, 0, 2}, '{2, 1, 0}};
        return t[c][p];
    endfunction
    function automatic int band2(int c, int p);
        int t [3][3] = '{'{1, 0, 2}, '{2, 1, 0}, '{0, 2, 1}};
        return t[c][p];
    endfunction

    function automatic logic [4*NCELL-1:0] model(int p, logic [2:0] a, logic [2:0] b);
        logic [4*NCELL-1:0] r;
        for (int c = 0; c < NCELL; c++) begin
            if (p < 0) begin
                r[4*c +: 4] = 4'b1010;
            end else begin
                logic s1, s3;
                s1 = a[band1(c, p)];
                s3 = b[band2(c, p)];
                r[4*c +: 4] = {~s3, s3, ~s1, s1};
            end
        end
        return r;
    endfunction

    task automatic check_gates(string tag);
        logic [4*NCELL-1:0] exp;
        exp = model(ph, leg1_band, leg2_band);
        checks++;
        if (gate_o !== exp) begin
            errors++;
            $display("FAIL %s: gate_o=%h expected %h (phase %0d)", tag, gate_o, exp, ph);
        end
    endtask

    task automatic check_spread(string tag);
        int u1, u2;
        u1 = 0; u2 = 0;
        for (int c = 0; c < NCELL; c++) begin
            u1 += gate_o[4*c];
            u2 += gate_o[4*c+2];
        end
        checks++;
        if (u1 != $countones(leg1_band) || u2 != $countones(leg2_band)) begin
            errors++;
            $display("FAIL %s: upper counts %0d/%0d expected %0d/%0d", tag,
                     u1, u2, $countones(leg1_band), $countones(leg2_band));
        end
    endtask

    task automatic quiet_strobe();
        @(negedge clk);
        half_strobe = 1'b1;
        @(negedge clk);
        half_strobe = 1'b0;
        ph = (ph < 0) ? 0 : (ph + 1) % 3;
    endtask

    task automatic set_bands(logic [2:0] a, logic [2:0] b);
        @(negedge clk);
        leg1_band = a;
        leg2_band = b;
        #1;
    endtask

    // {strobes, leg1, leg2}
    localparam logic [7:0] VEC [12] = '{
        {2'd1, 3'b111, 3'b000}, {2'd0, 3'b001, 3'b010}, {2'd0, 3'b100, 3'b001},
        {2'd1, 3'b010, 3'b100}, {2'd0, 3'b101, 3'b011}, {2'd1, 3'b001, 3'b110},
        {2'd0, 3'b110, 3'b001}, {2'd1, 3'b100, 3'b010}, {2'd0, 3'b011, 3'b101},
        {2'd2, 3'b001, 3'b100}, {2'd0, 3'b010, 3'b010}, {2'd1, 3'b111, 3'b111}
    };

    initial begin
        rst_n = 1'b0;
        half_strobe = 1'b0;
        leg1_band = '0;
        leg2_band = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: hold state ignores band activity
        set_bands(3'b111, 3'b101); check_gates("R1 hold after reset");
        set_bands(3'b010, 3'b111); check_gates("R1 hold with toggling bands");

        // vector walk: R2 first strobe, R3 rotation, R4 R5 R6 routing, R9 spread
        for (int i = 0; i < 12; i++) begin
            for (int s = 0; s < int'(VEC[i][7:6]); s++) quiet_strobe();
            set_bands(VEC[i][5:3], VEC[i][2:0]);
            check_gates(i == 0 ? "R2 first phase" : "R3 R4 R5 R6 vector");
            check_spread("R9 one cell per band");
        end

        // R7: strobe on a noisy edge is deferred to the next quiet edge
        @(negedge clk);
        half_strobe = 1'b1;
        leg1_band = 3'b100; leg2_band = 3'b001;
        @(negedge clk);
        half_strobe = 1'b0;
        #1 check_gates("R7 old routing while deferred");
        ph = (ph + 1) % 3;
        @(negedge clk);
        #1 check_gates("R7 committed on quiet edge");

        // R8: extra strobes during deferral are absorbed
        @(negedge clk);
        half_strobe = 1'b1;
        leg1_band = 3'b010; leg2_band = 3'b100;
        @(negedge clk);
        leg1_band = 3'b001; leg2_band = 3'b010;
        @(negedge clk);
        half_strobe = 1'b0;
        #1 check_gates("R8 still old routing");
        ph = (ph + 1) % 3;
        @(negedge clk);
        #1 check_gates("R8 single advance");
        quiet_strobe();
        #1 check_gates("R8 R3 next advance");

        // R1 R2 R7: reset mid-run, then noisy first strobe from hold
        @(negedge clk);
        rst_n = 1'b0;
        ph = -1;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check_gates("R1 hold after second reset");
        @(negedge clk);
        half_strobe = 1'b1;
        leg1_band = 3'b110; leg2_band = 3'b011;
        @(negedge clk);
        half_strobe = 1'b0;
        #1 check_gates("R1 R7 hold while start deferred");
        ph = 0;
        @(negedge clk);
        #1 check_gates("R2 phase 0 after deferred start");

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule